// File: doc/BRIEF.md
# BCD Calendar Counter with Init Mode

This block keeps the running time of day (seconds, minutes, hours) and the date (day of month, month, weekday, two-digit year) as packed BCD fields. A one-second tick comes from a pair of down-counting dividers on the RTC clock. A fast divider reloads from a 7-bit value, and a slow divider steps once per fast wrap and reloads from a 15-bit value. Hours run either in 24-hour form or in 12-hour form with an afternoon flag.

Software can only change the calendar through a handshaked setup mode. It raises a setup request and waits for the acknowledge output. It then loads the time word, the date word, the divider reload word and the hour-format bit, and drops the request. While the acknowledge is high, the counters and the dividers stand still. They restart from the loaded values once it falls. Readable copies of the time and date trail the live counters by a fixed crossing delay. A sync-valid flag tells software when those copies can be trusted again.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset, the readable time is 00:00:00, the readable date word is 0x00002101 (year 00, weekday 1, month 01, day 01), the acknowledge is low and the 24-hour format is selected.
- R2: The acknowledge rises two clock edges after the setup request is raised, and falls two edges after the request is dropped.
- R3: Writes of time, date, divider reload or format are ignored while the acknowledge is low.
- R4: While the acknowledge is high, the calendar does not change. The first second is counted exactly (A+1)*(S+1) edges after the edge on which the acknowledge falls.
- R5: The divider reload word carries A in bits [22:16] and S in bits [14:0]. `sec_tick` is high for one cycle every (A+1)*(S+1) cycles, on the cycle just before the counting edge.
- R6: The time word holds seconds in [6:0], minutes in [14:8] and hours in [21:16], all in BCD. Seconds and minutes wrap from 59 to 00 and carry. In 24-hour mode, hours wrap from 23 to 00 and advance the day.
- R7: The date word holds the day in [5:0], the month in [12:8], the weekday in [15:13] and the BCD year in [23:16]. The day wraps to 01 after 28, 29, 30 or 31 according to the month, and February has 29 days when the year is divisible by 4. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R8: The weekday (1 = Monday through 7 = Sunday) advances with each day and wraps from 7 to 1.
- R9: In 12-hour mode (format bit 1), hours run 12, 01 … 11 and time-word bit 22 is the afternoon flag. The step from 11 to 12 toggles the flag, and the step from 11 PM to 12 AM advances the day. A loaded afternoon flag is kept only when 12-hour mode is already selected.
- R10: The sync-valid flag is cleared by a clear pulse and while the acknowledge is high. It rises again two edges after the last edge that cleared it.
- R11: The readable time and date show a counter update two edges after the counting edge.
- R12: `cal_inits` is 0 while the year is 00 and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RTC clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | 1 | Setup-mode request level |
| init_ack | output | 1 | Setup-mode acknowledge |
| sync_clr | input | 1 | Pulse that clears the sync-valid flag |
| sync_ok | output | 1 | Readable copies match the live counters |
| fmt_wr | input | 1 | Load strobe for the hour format |
| fmt_12h | input | 1 | Format to load: 1 = 12-hour, 0 = 24-hour |
| tm_wr | input | 1 | Load strobe for the time word |
| tm_wdata | input | 32 | Time word to load |
| dt_wr | input | 1 | Load strobe for the date word |
| dt_wdata | input | 32 | Date word to load |
| psc_wr | input | 1 | Load strobe for the divider reload word |
| psc_wdata | input | 32 | Divider reload word |
| sec_tick | output | 1 | One-cycle pulse before each counting edge |
| time_rd | output | 32 | Readable time word |
| date_rd | output | 32 | Readable date word |
| fmt_rd | output | 1 | Current hour format |
| cal_inits | output | 1 | Calendar has been set (year not 00) |

## Verification
The acknowledge is due two edges after a request change. The sync-valid flag is due two edges after its last clearing edge. A counter update reaches the readable words two edges after its counting edge, and the counting edge falls (A+1)*(S+1) edges after the acknowledge drops. The bench drives on falling edges and counts edges from each stimulus to the exact cycle it samples. For example, with a ten-cycle second it reads the old value eleven edges after the acknowledge falls and the new value twelve edges after. It then re-enters setup mode before the next second so that each calendar case sees exactly one tick. Each date and time rollover is set up by loading the state one second before it.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  typedef struct packed {
    logic       pm;
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
  } cal_time_t;

  typedef struct packed {
    logic [7:0] year;
    logic [2:0] wday;
    logic [4:0] month;
    logic [5:0] day;
  } cal_date_t;

  typedef struct packed {
    cal_time_t t;
    cal_date_t d;
  } cal_snap_t;

  localparam cal_time_t TIME_RST = '0;
  localparam cal_date_t DATE_RST = '{year: 8'h00, wday: 3'd1, month: 5'h01, day: 6'h01};

  // BCD increment of a two-digit value (no range wrap)
  function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // divisible by 4, evaluated on the BCD digits
  function automatic logic bcd_leap(input logic [7:0] y);
    logic r;
    if (y[4]) r = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      r = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return r;
  endfunction

  function automatic logic [5:0] month_last_day(input logic [4:0] m, input logic [7:0] y);
    logic [5:0] r;
    case (m)
      5'h02:                     r = bcd_leap(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
      default:                   r = 6'h31;
    endcase
    return r;
  endfunction

  function automatic logic [31:0] pack_time(input cal_time_t t);
    return {9'd0, t.pm, t.hour, 1'b0, t.min, 1'b0, t.sec};
  endfunction

  function automatic logic [31:0] pack_date(input cal_date_t d);
    return {8'd0, d.year, d.wday, d.month, 2'b00, d.day};
  endfunction

endpackage

// File: rtl/rtc_init_sync.sv
module rtc_init_sync #(
  parameter int SYNC_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_req,
  input  logic sync_clr,
  output logic init_ack,
  output logic sync_ok
);
  localparam int CW = $clog2(SYNC_CYC + 1);

  logic [SYNC_CYC-1:0] req_sh_q, req_sh_d;
  logic [CW-1:0]       cnt_q, cnt_d;
  logic                ok_q, ok_d;

  assign init_ack = req_sh_q[SYNC_CYC-1];
  assign sync_ok  = ok_q;

  always_comb begin
    req_sh_d = {req_sh_q[SYNC_CYC-2:0], init_req};
  end

  always_comb begin
    cnt_d = cnt_q;
    ok_d  = ok_q;
    if (sync_clr || init_ack) begin
      cnt_d = '0;
      ok_d  = 1'b0;
    end else if (!ok_q) begin
      if (cnt_q == CW'(SYNC_CYC - 1)) ok_d = 1'b1;
      else                             cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_sh_q <= '0;
      cnt_q    <= '0;
      ok_q     <= 1'b0;
    end else begin
      req_sh_q <= req_sh_d;
      cnt_q    <= cnt_d;
      ok_q     <= ok_d;
    end
  end

  p_ack_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_ack) |-> $past(init_req));
  p_sync_low_init_r10: assert property (@(posedge clk) disable iff (!rst_n)
    init_ack |=> !sync_ok);
  p_sync_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> !sync_ok);
  p_sync_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_ok) |-> !$past(init_ack) && !$past(sync_clr));

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int A_W   = 7,
  parameter int S_W   = 15,
  parameter int A_RST = 127,
  parameter int S_RST = 255
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic           ld,
  input  logic [A_W-1:0] a_rl_in,
  input  logic [S_W-1:0] s_rl_in,
  output logic           tick
);
  logic [A_W-1:0] a_rl_q, a_cnt_q, a_cnt_d;
  logic [S_W-1:0] s_rl_q, s_cnt_q, s_cnt_d;
  logic           rl_en;

  assign rl_en = hold && ld;
  assign tick  = !hold && (a_cnt_q == '0) && (s_cnt_q == '0);

  always_comb begin
    a_cnt_d = a_cnt_q;
    s_cnt_d = s_cnt_q;
    if (hold) begin
      a_cnt_d = a_rl_q;
      s_cnt_d = s_rl_q;
    end else if (a_cnt_q == '0) begin
      a_cnt_d = a_rl_q;
      s_cnt_d = (s_cnt_q == '0) ? s_rl_q : s_cnt_q - 1'b1;
    end else begin
      a_cnt_d = a_cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rl_q <= A_W'(A_RST);
      s_rl_q <= S_W'(S_RST);
    end else if (rl_en) begin
      a_rl_q <= a_rl_in;
      s_rl_q <= s_rl_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_cnt_q <= A_W'(A_RST);
      s_cnt_q <= S_W'(S_RST);
    end else begin
      a_cnt_q <= a_cnt_d;
      s_cnt_q <= s_cnt_d;
    end
  end

  p_reload_after_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (a_cnt_q == a_rl_q) && (s_cnt_q == s_rl_q));
  p_no_tick_in_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !tick);

endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import rtc_cal_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hold,
  input  logic      tick,
  input  logic      fmt12,
  input  logic      ld,
  input  cal_time_t ld_val,
  output cal_time_t cur,
  output logic      day_carry
);
  cal_time_t cur_q, cur_d;
  logic [7:0] sec_inc, min_inc, hr_inc;
  logic sec_end, min_end, carry, upd_en;

  assign cur       = cur_q;
  assign day_carry = carry;
  assign upd_en    = (hold && ld) || (!hold && tick);

  always_comb begin
    cur_d   = cur_q;
    carry   = 1'b0;
    sec_inc = bcd_inc8({1'b0, cur_q.sec});
    min_inc = bcd_inc8({1'b0, cur_q.min});
    hr_inc  = bcd_inc8({2'b00, cur_q.hour});
    sec_end = (cur_q.sec == 7'h59);
    min_end = (cur_q.min == 7'h59);
    if (hold) begin
      if (ld) begin
        cur_d    = ld_val;
        cur_d.pm = ld_val.pm & fmt12;
      end
    end else if (tick) begin
      cur_d.sec = sec_end ? 7'h00 : sec_inc[6:0];
      if (sec_end) begin
        cur_d.min = min_end ? 7'h00 : min_inc[6:0];
        if (min_end) begin
          if (fmt12) begin
            if (cur_q.hour == 6'h12) begin
              cur_d.hour = 6'h01;
            end else if (cur_q.hour == 6'h11) begin
              cur_d.hour = 6'h12;
              cur_d.pm   = ~cur_q.pm;
              carry      = cur_q.pm;
            end else begin
              cur_d.hour = hr_inc[5:0];
            end
          end else begin
            if (cur_q.hour == 6'h23) begin
              cur_d.hour = 6'h00;
              carry      = 1'b1;
            end else begin
              cur_d.hour = hr_inc[5:0];
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= TIME_RST;
    else if (upd_en) cur_q <= cur_d;
  end

  p_hold_time_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !ld) |=> $stable(cur_q));
  p_sec_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cur_q.sec == 7'h59) |=> cur_q.sec == 7'h00);
  p_carry_hour_r6: assert property (@(posedge clk) disable iff (!rst_n)
    day_carry |=> cur_q.hour == ($past(fmt12) ? 6'h12 : 6'h00));
  p_pm_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && fmt12 && cur_q.hour == 6'h11 && cur_q.min == 7'h59 && cur_q.sec == 7'h59)
      |=> cur_q.pm != $past(cur_q.pm));

endmodule

// File: rtl/rtc_date_counter.sv
module rtc_date_counter
  import rtc_cal_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hold,
  input  logic      day_inc,
  input  logic      ld,
  input  cal_date_t ld_val,
  output cal_date_t cur
);
  cal_date_t  cur_q, cur_d;
  logic [7:0] day_nx, mon_nx, yr_nx;
  logic [5:0] last_day;
  logic       upd_en;

  assign cur    = cur_q;
  assign upd_en = (hold && ld) || (!hold && day_inc);

  always_comb begin
    cur_d    = cur_q;
    day_nx   = bcd_inc8({2'b00, cur_q.day});
    mon_nx   = bcd_inc8({3'b000, cur_q.month});
    yr_nx    = bcd_inc8(cur_q.year);
    last_day = month_last_day(cur_q.month, cur_q.year);
    if (hold) begin
      if (ld) cur_d = ld_val;
    end else if (day_inc) begin
      cur_d.wday = (cur_q.wday == 3'd7) ? 3'd1 : cur_q.wday + 3'd1;
      if (cur_q.day == last_day) begin
        cur_d.day = 6'h01;
        if (cur_q.month == 5'h12) begin
          cur_d.month = 5'h01;
          cur_d.year  = (cur_q.year == 8'h99) ? 8'h00 : yr_nx;
        end else begin
          cur_d.month = mon_nx[4:0];
        end
      end else begin
        cur_d.day = day_nx[5:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= DATE_RST;
    else if (upd_en) cur_q <= cur_d;
  end

  p_hold_date_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !ld) |=> $stable(cur_q));
  p_wday_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (day_inc && !hold && cur_q.wday == 3'd7) |=> cur_q.wday == 3'd1);
  p_year_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (day_inc && !hold && cur_q.month == 5'h12 && cur_q.day == 6'h31)
      |=> (cur_q.month == 5'h01) && (cur_q.day == 6'h01));

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int SYNC_CYC = 2,
  parameter int A_W      = 7,
  parameter int S_W      = 15,
  parameter int A_RST    = 127,
  parameter int S_RST    = 255
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init_req,
  output logic        init_ack,
  input  logic        sync_clr,
  output logic        sync_ok,
  input  logic        fmt_wr,
  input  logic        fmt_12h,
  input  logic        tm_wr,
  input  logic [31:0] tm_wdata,
  input  logic        dt_wr,
  input  logic [31:0] dt_wdata,
  input  logic        psc_wr,
  input  logic [31:0] psc_wdata,
  output logic        sec_tick,
  output logic [31:0] time_rd,
  output logic [31:0] date_rd,
  output logic        fmt_rd,
  output logic        cal_inits
);
  localparam int A_LSB = 16;

  logic      ack, tick, day_carry, fmt_q, fmt_d, fmt_en;
  cal_time_t tm_ld, tm_live;
  cal_date_t dt_ld, dt_live;
  cal_snap_t live_snap;
  cal_snap_t shadow_q [SYNC_CYC];
  logic      unused_bits;

  assign unused_bits = ^{tm_wdata[31:23], tm_wdata[15], tm_wdata[7],
                         dt_wdata[31:24], dt_wdata[7:6],
                         psc_wdata[31:A_LSB+A_W], psc_wdata[A_LSB-1:S_W]};

  assign tm_ld = '{pm: tm_wdata[22], hour: tm_wdata[21:16], min: tm_wdata[14:8], sec: tm_wdata[6:0]};
  assign dt_ld = '{year: dt_wdata[23:16], wday: dt_wdata[15:13], month: dt_wdata[12:8], day: dt_wdata[5:0]};

  rtc_init_sync #(.SYNC_CYC(SYNC_CYC)) u_sync (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .sync_clr(sync_clr),
    .init_ack(ack), .sync_ok(sync_ok)
  );

  rtc_prescaler #(.A_W(A_W), .S_W(S_W), .A_RST(A_RST), .S_RST(S_RST)) u_psc (
    .clk(clk), .rst_n(rst_n), .hold(ack), .ld(psc_wr),
    .a_rl_in(psc_wdata[A_LSB +: A_W]), .s_rl_in(psc_wdata[0 +: S_W]),
    .tick(tick)
  );

  rtc_time_counter u_time (
    .clk(clk), .rst_n(rst_n), .hold(ack), .tick(tick), .fmt12(fmt_q),
    .ld(tm_wr), .ld_val(tm_ld), .cur(tm_live), .day_carry(day_carry)
  );

  rtc_date_counter u_date (
    .clk(clk), .rst_n(rst_n), .hold(ack), .day_inc(day_carry),
    .ld(dt_wr), .ld_val(dt_ld), .cur(dt_live)
  );

  // hour format register, loadable only in setup mode
  assign fmt_en = ack && fmt_wr;
  always_comb fmt_d = fmt_12h;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fmt_q <= 1'b0;
    else if (fmt_en) fmt_q <= fmt_d;
  end

  // readable copies: fixed crossing delay of SYNC_CYC stages
  assign live_snap = '{t: tm_live, d: dt_live};

  for (genvar i = 0; i < SYNC_CYC; i++) begin : g_shadow
    cal_snap_t stage_d;
    if (i == 0) begin : g_first
      always_comb stage_d = live_snap;
    end else begin : g_next
      always_comb stage_d = shadow_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shadow_q[i] <= '{t: TIME_RST, d: DATE_RST};
      else        shadow_q[i] <= stage_d;
    end
  end

  assign init_ack  = ack;
  assign sec_tick  = tick;
  assign fmt_rd    = fmt_q;
  assign time_rd   = pack_time(shadow_q[SYNC_CYC-1].t);
  assign date_rd   = pack_date(shadow_q[SYNC_CYC-1].d);
  assign cal_inits = (dt_live.year != 8'h00);

  p_fmt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !init_ack |=> $stable(fmt_rd));
  p_tick_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    init_ack |-> !sec_tick);

endmodule

// File: tb/rtc_calendar_core_bench.sv
`timescale 1ns/1ps
module rtc_calendar_core_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        init_req, sync_clr, fmt_wr, fmt_12h, tm_wr, dt_wr, psc_wr;
  logic [31:0] tm_wdata, dt_wdata, psc_wdata;
  logic        init_ack, sync_ok, sec_tick, fmt_rd, cal_inits;
  logic [31:0] time_rd, date_rd;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  rtc_calendar_core u_rtc_calendar_core (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_ack(init_ack),
    .sync_clr(sync_clr), .sync_ok(sync_ok), .fmt_wr(fmt_wr), .fmt_12h(fmt_12h),
    .tm_wr(tm_wr), .tm_wdata(tm_wdata), .dt_wr(dt_wr), .dt_wdata(dt_wdata),
    .psc_wr(psc_wr), .psc_wdata(psc_wdata), .sec_tick(sec_tick),
    .time_rd(time_rd), .date_rd(date_rd), .fmt_rd(fmt_rd), .cal_inits(cal_inits)
  );

  function automatic logic [31:0] tword(input logic pm, input logic [5:0] h,
                                        input logic [6:0] m, input logic [6:0] s);
    return {9'd0, pm, h, 1'b0, m, 1'b0, s};
  endfunction

  function automatic logic [31:0] dword(input logic [7:0] y, input logic [2:0] w,
                                        input logic [4:0] mo, input logic [5:0] d);
    return {8'd0, y, w, mo, 2'b00, d};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic nxt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter_init();
    init_req = 1'b1;
    nxt(3);
  endtask

  // drop request; returns at the negedge after the edge where ack falls
  task automatic leave_init();
    init_req = 1'b0;
    nxt(2);
  endtask

  task automatic ld_time(input logic [31:0] v);
    tm_wr = 1'b1; tm_wdata = v; nxt(1); tm_wr = 1'b0;
  endtask

  task automatic ld_date(input logic [31:0] v);
    dt_wr = 1'b1; dt_wdata = v; nxt(1); dt_wr = 1'b0;
  endtask

  task automatic ld_psc(input logic [6:0] a, input logic [14:0] s);
    psc_wr = 1'b1; psc_wdata = {9'd0, a, 1'b0, s}; nxt(1); psc_wr = 1'b0;
  endtask

  task automatic ld_fmt(input logic f);
    fmt_wr = 1'b1; fmt_12h = f; nxt(1); fmt_wr = 1'b0;
  endtask

  // one second of ten cycles, then back in setup mode before the next
  task automatic one_tick();
    leave_init();
    nxt(12);
    enter_init();
  endtask

  task automatic step_case(input string req, input logic [31:0] t0, input logic [31:0] d0,
                           input logic [31:0] t1, input logic [31:0] d1);
    ld_time(t0);
    ld_date(d0);
    one_tick();
    chk({req, " time"}, time_rd, t1);
    chk({req, " date"}, date_rd, d1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; init_req = 1'b0; sync_clr = 1'b0; fmt_wr = 1'b0; fmt_12h = 1'b0;
    tm_wr = 1'b0; dt_wr = 1'b0; psc_wr = 1'b0;
    tm_wdata = '0; dt_wdata = '0; psc_wdata = '0;
    nxt(3);
    rst_n = 1'b1;
    nxt(1);
    chk("R1 time", time_rd, 32'h0);
    chk("R1 date", date_rd, 32'h0000_2101);
    chk("R1 ack", {31'd0, init_ack}, 32'd0);
    chk("R1 fmt", {31'd0, fmt_rd}, 32'd0);
    chk("R12 inits at year 00", {31'd0, cal_inits}, 32'd0);
    chk("R10 sync low one edge after reset", {31'd0, sync_ok}, 32'd0);
    nxt(1);
    chk("R10 sync high two edges after reset", {31'd0, sync_ok}, 32'd1);
  endtask

  task automatic t_guard();
    ld_time(tword(1'b0, 6'h12, 7'h34, 7'h56));
    ld_date(dword(8'h24, 3'd3, 5'h05, 6'h15));
    ld_fmt(1'b1);
    nxt(3);
    chk("R3 time write ignored", time_rd, 32'h0);
    chk("R3 date write ignored", date_rd, 32'h0000_2101);
    chk("R3 fmt write ignored", {31'd0, fmt_rd}, 32'd0);
  endtask

  task automatic t_handshake();
    init_req = 1'b1;
    nxt(1);
    chk("R2 ack low after one edge", {31'd0, init_ack}, 32'd0);
    nxt(1);
    chk("R2 ack high after two edges", {31'd0, init_ack}, 32'd1);
    nxt(1);
    chk("R10 sync cleared in setup", {31'd0, sync_ok}, 32'd0);
    init_req = 1'b0;
    nxt(1);
    chk("R2 ack still high one edge after drop", {31'd0, init_ack}, 32'd1);
    nxt(1);
    chk("R2 ack low two edges after drop", {31'd0, init_ack}, 32'd0);
    enter_init();
  endtask

  task automatic t_freeze_period();
    bit ok_pat = 1'b1;
    ld_time(tword(1'b0, 6'h12, 7'h34, 7'h56));
    ld_date(dword(8'h24, 3'd3, 5'h05, 6'h15));
    ld_psc(7'd1, 15'd2);
    nxt(20);
    chk("R4 frozen in setup", time_rd, tword(1'b0, 6'h12, 7'h34, 7'h56));
    leave_init();
    for (int k = 1; k <= 12; k++) begin
      nxt(1);
      if (sec_tick !== ((k == 5) || (k == 11))) begin
        ok_pat = 1'b0;
        $display("FAIL R5 tick at edge +%0d actual=%0b expected=%0b", k, sec_tick, (k == 5) || (k == 11));
      end
    end
    n_chk++;
    if (!ok_pat) n_fail++;
    enter_init();
    chk("R4 two seconds after restart", time_rd, tword(1'b0, 6'h12, 7'h34, 7'h58));
    nxt(10);
    chk("R4 frozen again", time_rd, tword(1'b0, 6'h12, 7'h34, 7'h58));
    ld_psc(7'd0, 15'd9);
  endtask

  task automatic t_sync_flag();
    leave_init();
    chk("R10 sync low at ack fall", {31'd0, sync_ok}, 32'd0);
    nxt(1);
    chk("R10 sync low one edge later", {31'd0, sync_ok}, 32'd0);
    nxt(1);
    chk("R10 sync high two edges later", {31'd0, sync_ok}, 32'd1);
    sync_clr = 1'b1;
    nxt(1);
    sync_clr = 1'b0;
    chk("R10 sync cleared by pulse", {31'd0, sync_ok}, 32'd0);
    nxt(1);
    chk("R10 sync low after pulse", {31'd0, sync_ok}, 32'd0);
    nxt(1);
    chk("R10 sync back after pulse", {31'd0, sync_ok}, 32'd1);
    enter_init();
    chk("R4 no second before ten cycles", time_rd, tword(1'b0, 6'h12, 7'h34, 7'h58));
  endtask

  task automatic t_shadow();
    leave_init();
    nxt(9);
    chk("R5 tick before counting edge", {31'd0, sec_tick}, 32'd1);
    nxt(2);
    chk("R11 old value one edge after count", time_rd, tword(1'b0, 6'h12, 7'h34, 7'h58));
    nxt(1);
    chk("R11 new value two edges after count", time_rd, tword(1'b0, 6'h12, 7'h34, 7'h59));
    enter_init();
  endtask

  task automatic t_wraps();
    step_case("R6 minute wrap", tword(1'b0, 6'h10, 7'h59, 7'h59), dword(8'h24, 3'd3, 5'h05, 6'h15),
              tword(1'b0, 6'h11, 7'h00, 7'h00), dword(8'h24, 3'd3, 5'h05, 6'h15));
    step_case("R6 R8 midnight", tword(1'b0, 6'h23, 7'h59, 7'h59), dword(8'h24, 3'd7, 5'h03, 6'h31),
              tword(1'b0, 6'h00, 7'h00, 7'h00), dword(8'h24, 3'd1, 5'h04, 6'h01));
  endtask

  task automatic t_months();
    logic [31:0] mid = tword(1'b0, 6'h23, 7'h59, 7'h59);
    logic [31:0] zero = tword(1'b0, 6'h00, 7'h00, 7'h00);
    step_case("R7 leap feb 28", mid, dword(8'h24, 3'd3, 5'h02, 6'h28), zero, dword(8'h24, 3'd4, 5'h02, 6'h29));
    step_case("R7 leap feb 29", mid, dword(8'h24, 3'd4, 5'h02, 6'h29), zero, dword(8'h24, 3'd5, 5'h03, 6'h01));
    step_case("R7 plain feb", mid, dword(8'h23, 3'd2, 5'h02, 6'h28), zero, dword(8'h23, 3'd3, 5'h03, 6'h01));
    step_case("R7 year 18 feb", mid, dword(8'h18, 3'd3, 5'h02, 6'h28), zero, dword(8'h18, 3'd4, 5'h03, 6'h01));
    step_case("R7 year 12 feb", mid, dword(8'h12, 3'd2, 5'h02, 6'h28), zero, dword(8'h12, 3'd3, 5'h02, 6'h29));
    step_case("R7 30-day month", mid, dword(8'h24, 3'd2, 5'h04, 6'h30), zero, dword(8'h24, 3'd3, 5'h05, 6'h01));
    step_case("R7 day 09 to 10", mid, dword(8'h24, 3'd2, 5'h09, 6'h09), zero, dword(8'h24, 3'd3, 5'h09, 6'h10));
    step_case("R7 december", mid, dword(8'h24, 3'd2, 5'h12, 6'h31), zero, dword(8'h25, 3'd3, 5'h01, 6'h01));
    chk("R12 inits with year 25", {31'd0, cal_inits}, 32'd1);
    step_case("R7 century", mid, dword(8'h99, 3'd5, 5'h12, 6'h31), zero, dword(8'h00, 3'd6, 5'h01, 6'h01));
    chk("R12 inits after year wraps to 00", {31'd0, cal_inits}, 32'd0);
  endtask

  task automatic t_twelve();
    ld_fmt(1'b1);
    chk("R9 format loaded in setup", {31'd0, fmt_rd}, 32'd1);
    step_case("R9 noon", tword(1'b0, 6'h11, 7'h59, 7'h59), dword(8'h24, 3'd5, 5'h05, 6'h10),
              tword(1'b1, 6'h12, 7'h00, 7'h00), dword(8'h24, 3'd5, 5'h05, 6'h10));
    step_case("R9 midnight", tword(1'b1, 6'h11, 7'h59, 7'h59), dword(8'h24, 3'd5, 5'h05, 6'h10),
              tword(1'b0, 6'h12, 7'h00, 7'h00), dword(8'h24, 3'd6, 5'h05, 6'h11));
    step_case("R9 twelve to one", tword(1'b1, 6'h12, 7'h59, 7'h59), dword(8'h24, 3'd5, 5'h05, 6'h10),
              tword(1'b1, 6'h01, 7'h00, 7'h00), dword(8'h24, 3'd5, 5'h05, 6'h10));
    ld_fmt(1'b0);
    ld_time(tword(1'b1, 6'h10, 7'h00, 7'h00));
    nxt(3);
    chk("R9 afternoon flag dropped in 24-hour mode", time_rd, tword(1'b0, 6'h10, 7'h00, 7'h00));
  endtask

  initial begin
    t_reset();
    t_guard();
    t_handshake();
    t_freeze_period();
    t_sync_flag();
    t_shadow();
    t_wraps();
    t_months();
    t_twelve();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R2 actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule